// File: doc/BRIEF.md
# USB OUT Endpoint Receive FIFO

This block stores the payload of USB OUT data packets for one endpoint and decides, at the start of each OUT transaction, whether the data can be accepted (ACK) or must be refused (NAK). A packet engine upstream delivers an abstract start-of-transaction strobe, a byte strobe with data, and an end-of-packet pulse with a good/bad indication. The ACK/NAK decision goes back to that engine one cycle after the strobe.

On the CPU side, a status flag marks that a complete packet has arrived. A count register holds that packet's byte length, and a byte read port unloads the FIFO. While the flag is set, every further OUT transaction is refused. Software reads the count, then clears the flag with a write-1 pulse. From then on it may keep draining the earlier packet while the next one is written into the same storage. A packet that ends bad is thrown away by rolling the write pointer back.

Top module: `usb_out_rx_fifo`

## Requirements
- R1: After a synchronous reset, `pkt_flag`, `irq`, `resp_valid`, `resp_ack`, `cpu_count` and `cpu_rdata` are all zero.
- R2: `resp_valid` is high for exactly one cycle, in the cycle after each `tok_out` pulse, and is low at all other times.
- R3: A transaction is answered NAK (`resp_ack`=0) when the free space (DEPTH minus stored bytes, counting bytes not yet read) is less than MAXPKT at the token.
- R4: A transaction is answered NAK while `pkt_flag` is set, even when there is room.
- R5: A transaction is answered ACK when no packet is being received, `pkt_flag` is clear and there is room. A token that arrives while an accepted packet is still open is answered NAK.
- R6: A good end of an accepted packet sets `pkt_flag` in the next cycle. `irq` is high exactly when `pkt_flag` and `irq_en` are both high.
- R7: `cpu_count` takes the byte length of each good packet at its end and keeps that value until the next good end. A bad end or an ignored end leaves it unchanged.
- R8: A bad end (`pk_good`=0) leaves `pkt_flag` clear and discards every byte of that packet. Those bytes are never readable, and their space is free again.
- R9: A `cpu_clr` pulse clears `pkt_flag`. If it coincides with a good end, the flag ends up set.
- R10: `cpu_rdata` presents the stored bytes in arrival order, one cycle after each `cpu_rd`. Reads of earlier packets may proceed while a new packet is being stored. Bytes of a packet that has not yet ended well are not readable.
- R11: A `cpu_rd` with no readable byte returns zero and consumes nothing.
- R12: Bytes past the first MAXPKT of a packet are dropped. Byte strobes and end pulses outside an accepted packet have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_out | input | 1 | Pulse: a new OUT transaction begins |
| pk_wr | input | 1 | Byte strobe from the packet engine |
| pk_data | input | 8 | Payload byte |
| pk_end | input | 1 | Pulse: end of the data packet |
| pk_good | input | 1 | With pk_end: 1 = packet intact, 0 = discard |
| resp_valid | output | 1 | Handshake decision valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |
| cpu_rd | input | 1 | CPU byte read pulse |
| cpu_rdata | output | 8 | Byte returned by the previous read |
| cpu_clr | input | 1 | Write-1 pulse clearing the packet flag |
| irq_en | input | 1 | Interrupt enable for the packet flag |
| pkt_flag | output | 1 | Packet-received status flag |
| irq | output | 1 | Interrupt request |
| cpu_count | output | clog2(MAXPKT+1) | Byte length of the last good packet |

## Verification
A sweep over every packet length from zero to beyond MAXPKT shows that the latched count, the data order and the drop of excess bytes follow the length arithmetic, and not a fixed size. Each sweep step also probes a token while the flag is set and reads past the end of the data. This separates refusal by flag from refusal by room, and an empty read from a stale byte. A directed sequence then fills the storage to just under and just over the room limit and interleaves reads with a packet in progress. It also ends one packet bad, lands a good end on the same cycle as a clear, and sends strobes outside any packet. Each of these cases exposes one ordering rule.

// File: rtl/oep_pkg.sv
package oep_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic ack;
    } hs_t;

    // handshake decision for one token
    function automatic hs_t hs_decide(logic tok, logic busy, logic flag, logic room);
        hs_t r;
        r.valid = tok;
        r.ack   = tok && !busy && !flag && room;
        return r;
    endfunction

endpackage

// File: rtl/oep_gate.sv
module oep_gate
    import oep_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MAXPKT = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int CW = $clog2(MAXPKT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_out,
    input  logic          pk_wr,
    input  logic          pk_end,
    input  logic          pk_good,
    input  logic          cpu_rd,
    input  logic          flag,
    output hs_t           hs,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          rd_take,
    output logic          rx_busy,
    output logic          good_end,
    output logic [CW-1:0] len_next,
    output logic [PW-1:0] level,
    output logic          empty
);

    rx_state_e     st;
    logic [PW-1:0] wptr, cptr, rptr, free, wnext;
    logic [CW-1:0] len;
    logic          room, bad_end;
    hs_t           hs_next;

    always_comb begin
        rx_busy  = (st == RX_BUSY);
        level    = wptr - rptr;
        free     = PW'(DEPTH) - level;
        room     = (free >= PW'(MAXPKT));
        hs_next  = hs_decide(tok_out, rx_busy, flag, room);
        wr_en    = rx_busy && pk_wr && (len < CW'(MAXPKT));
        wnext    = wptr + PW'(wr_en);
        len_next = len + CW'(wr_en);
        good_end = rx_busy && pk_end && pk_good;
        bad_end  = rx_busy && pk_end && !pk_good;
        empty    = (rptr == cptr);
        rd_take  = cpu_rd && !empty;
        waddr    = wptr[AW-1:0];
        raddr    = rptr[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RX_IDLE;
            hs   <= '0;
            wptr <= '0;
            cptr <= '0;
            rptr <= '0;
            len  <= '0;
        end else begin
            hs <= hs_next;
            if (rd_take) rptr <= rptr + PW'(1);
            unique case (st)
                RX_IDLE: begin
                    if (hs_next.ack) begin
                        st  <= RX_BUSY;
                        len <= '0;
                    end
                end
                RX_BUSY: begin
                    wptr <= wnext;
                    len  <= len_next;
                    if (good_end) begin
                        cptr <= wnext;
                        st   <= RX_IDLE;
                    end else if (bad_end) begin
                        wptr <= cptr;
                        st   <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/oep_store.sv
module oep_store #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          cpu_rd,
    input  logic          rd_take,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (cpu_rd) rdata <= rd_take ? mem[raddr] : 8'h00;
    end

endmodule

// File: rtl/oep_stat.sv
module oep_stat #(
    parameter int MAXPKT = 64,
    localparam int CW = $clog2(MAXPKT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          good_end,
    input  logic [CW-1:0] len_next,
    input  logic          cpu_clr,
    input  logic          irq_en,
    output logic          flag,
    output logic [CW-1:0] count,
    output logic          irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            count <= '0;
        end else begin
            flag <= (flag && !cpu_clr) || good_end;
            if (good_end) count <= len_next;
        end
    end

    assign irq = flag && irq_en;

endmodule

// File: rtl/usb_out_rx_fifo.sv
module usb_out_rx_fifo
    import oep_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MAXPKT = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int CW = $clog2(MAXPKT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_out,
    input  logic          pk_wr,
    input  logic [7:0]    pk_data,
    input  logic          pk_end,
    input  logic          pk_good,
    output logic          resp_valid,
    output logic          resp_ack,
    input  logic          cpu_rd,
    output logic [7:0]    cpu_rdata,
    input  logic          cpu_clr,
    input  logic          irq_en,
    output logic          pkt_flag,
    output logic          irq,
    output logic [CW-1:0] cpu_count
);

    hs_t           hs;
    logic          wr_en, rd_take, rx_busy, good_end, rd_empty;
    logic [AW-1:0] waddr, raddr;
    logic [CW-1:0] len_next;
    logic [PW-1:0] level;

    oep_gate #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_gate (
        .clk(clk), .rst(rst), .tok_out(tok_out), .pk_wr(pk_wr),
        .pk_end(pk_end), .pk_good(pk_good), .cpu_rd(cpu_rd), .flag(pkt_flag),
        .hs(hs), .wr_en(wr_en), .waddr(waddr), .raddr(raddr),
        .rd_take(rd_take), .rx_busy(rx_busy), .good_end(good_end),
        .len_next(len_next), .level(level), .empty(rd_empty)
    );

    oep_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr), .wdata(pk_data),
        .cpu_rd(cpu_rd), .rd_take(rd_take), .raddr(raddr), .rdata(cpu_rdata)
    );

    oep_stat #(.MAXPKT(MAXPKT)) u_stat (
        .clk(clk), .rst(rst), .good_end(good_end), .len_next(len_next),
        .cpu_clr(cpu_clr), .irq_en(irq_en), .flag(pkt_flag),
        .count(cpu_count), .irq(irq)
    );

    assign resp_valid = hs.valid;
    assign resp_ack   = hs.ack;

endmodule

// File: rtl/oep_chk.sv
module oep_chk #(
    parameter int DEPTH  = 64,
    parameter int MAXPKT = 64,
    localparam int PW = $clog2(DEPTH) + 1,
    localparam int CW = $clog2(MAXPKT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_out,
    input logic          pk_end,
    input logic          pk_good,
    input logic          cpu_rd,
    input logic          cpu_clr,
    input logic          resp_valid,
    input logic          resp_ack,
    input logic          pkt_flag,
    input logic [CW-1:0] cpu_count,
    input logic [7:0]    cpu_rdata,
    input logic          rx_busy,
    input logic          rd_empty,
    input logic [PW-1:0] level
);

    a_r2_resp_after_token: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> resp_valid);
    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !tok_out |=> !resp_valid);
    a_r3_nak_no_room: assert property (@(posedge clk) disable iff (rst)
        tok_out && (level > PW'(DEPTH - MAXPKT)) |=> !resp_ack);
    a_r4_nak_flag: assert property (@(posedge clk) disable iff (rst)
        tok_out && pkt_flag |=> !resp_ack);
    a_r5_nak_busy: assert property (@(posedge clk) disable iff (rst)
        tok_out && rx_busy |=> !resp_ack);
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
        !pkt_flag && !(rx_busy && pk_end && pk_good) |=> !pkt_flag);
    a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
        !(rx_busy && pk_end && pk_good) |=> $stable(cpu_count));
    a_r8_bad_end_no_flag: assert property (@(posedge clk) disable iff (rst)
        rx_busy && pk_end && !pk_good && !pkt_flag |=> !pkt_flag);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        rx_busy && pk_end && pk_good |=> pkt_flag);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        cpu_clr && !(rx_busy && pk_end && pk_good) |=> !pkt_flag);
    a_r11_empty_zero: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && rd_empty |=> cpu_rdata == 8'h00);
    a_r12_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));

endmodule

bind usb_out_rx_fifo oep_chk #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_chk (
    .clk(clk), .rst(rst), .tok_out(tok_out), .pk_end(pk_end), .pk_good(pk_good),
    .cpu_rd(cpu_rd), .cpu_clr(cpu_clr), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .pkt_flag(pkt_flag), .cpu_count(cpu_count),
    .cpu_rdata(cpu_rdata), .rx_busy(rx_busy), .rd_empty(rd_empty), .level(level)
);

// File: tb/sim_usb_out_rx_fifo.sv
module sim_usb_out_rx_fifo;

    localparam int DEPTH  = 16;
    localparam int MAXPKT = 8;
    localparam int CW     = $clog2(MAXPKT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tok_out = 0, pk_wr = 0, pk_end = 0, pk_good = 0;
    logic [7:0]    pk_data = 0;
    logic          cpu_rd = 0, cpu_clr = 0, irq_en = 0;
    logic          resp_valid, resp_ack, pkt_flag, irq;
    logic [7:0]    cpu_rdata;
    logic [CW-1:0] cpu_count;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    usb_out_rx_fifo #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u0 (
        .clk(clk), .rst(rst), .tok_out(tok_out), .pk_wr(pk_wr), .pk_data(pk_data),
        .pk_end(pk_end), .pk_good(pk_good), .resp_valid(resp_valid),
        .resp_ack(resp_ack), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .cpu_clr(cpu_clr), .irq_en(irq_en), .pkt_flag(pkt_flag), .irq(irq),
        .cpu_count(cpu_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic token(input bit exp_ack, input string req);
        tok_out = 1'b1;
        tick();
        tok_out = 1'b0;
        check("R2", "resp_valid after token", int'(resp_valid), 1);
        check(req, "resp_ack", int'(resp_ack), int'(exp_ack));
        tick();
        check("R2", "resp_valid one cycle", int'(resp_valid), 0);
    endtask

    task automatic put(input logic [7:0] b);
        pk_wr = 1'b1; pk_data = b;
        tick();
        pk_wr = 1'b0;
    endtask

    task automatic fin(input bit good, input bit with_clr);
        pk_end = 1'b1; pk_good = good; cpu_clr = with_clr;
        tick();
        pk_end = 1'b0; pk_good = 1'b0; cpu_clr = 1'b0;
    endtask

    task automatic rd(input int exp, input string req);
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
        check(req, "cpu_rdata", int'(cpu_rdata), exp);
    endtask

    task automatic clr();
        cpu_clr = 1'b1;
        tick();
        cpu_clr = 1'b0;
        check("R9", "flag after clear", int'(pkt_flag), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1", "pkt_flag", int'(pkt_flag), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "resp_valid", int'(resp_valid), 0);
        check("R1", "resp_ack", int'(resp_ack), 0);
        check("R1", "cpu_count", int'(cpu_count), 0);
        check("R1", "cpu_rdata", int'(cpu_rdata), 0);

        // length sweep: 0 .. MAXPKT+2 bytes into an empty FIFO
        for (int len = 0; len <= MAXPKT + 2; len++) begin
            int kept;
            kept = (len < MAXPKT) ? len : MAXPKT;
            irq_en = len[0];
            token(1'b1, "R5");
            for (int i = 0; i < len; i++) put(8'(len * 16 + i));
            fin(1'b1, 1'b0);
            check("R6", "flag after good end", int'(pkt_flag), 1);
            check("R6", "irq vs enable", int'(irq), int'(irq_en));
            check("R7", "count latched", int'(cpu_count), kept);   // R12 cap
            token(1'b0, "R4");                                    // flag blocks
            clr();
            check("R6", "irq after clear", int'(irq), 0);
            for (int i = 0; i < kept; i++) rd((len * 16 + i) & 255, "R10");
            rd(0, "R11");
            rd(0, "R11");
        end
        irq_en = 1'b0;

        // fill towards the room limit, overlap reads with storing
        token(1'b1, "R5");
        for (int i = 0; i < 8; i++) put(8'(8'hA0 + i));
        fin(1'b1, 1'b0);
        clr();
        token(1'b1, "R5");                 // 8 stored, 8 free: exactly enough
        put(8'hB0); put(8'hB1);
        rd(8'hA0, "R10");
        put(8'hB2);
        rd(8'hA1, "R10");
        put(8'hB3);
        fin(1'b1, 1'b0);
        check("R7", "count second packet", int'(cpu_count), 4);
        clr();
        token(1'b0, "R3");                 // 10 stored, 6 free, flag clear
        for (int i = 2; i < 8; i++) rd(8'hA0 + i, "R10");
        token(1'b1, "R3");                 // 4 stored, 12 free
        rd(8'hB0, "R10");
        put(8'hC0); put(8'hC1);
        rd(8'hB1, "R10"); rd(8'hB2, "R10"); rd(8'hB3, "R10");
        rd(0, "R10");                      // open packet not readable
        token(1'b0, "R5");                 // packet still open
        put(8'hC2);
        fin(1'b0, 1'b0);                   // bad end
        check("R8", "flag after bad end", int'(pkt_flag), 0);
        check("R7", "count kept on bad end", int'(cpu_count), 4);
        rd(0, "R8");

        // set wins over clear in the same cycle
        token(1'b1, "R8");
        put(8'hD0);
        fin(1'b1, 1'b1);
        check("R9", "set wins", int'(pkt_flag), 1);
        check("R7", "count one byte", int'(cpu_count), 1);
        token(1'b0, "R4");
        rd(8'hD0, "R10");
        clr();

        // strobes outside an accepted packet are ignored
        put(8'hEE);
        fin(1'b1, 1'b0);
        check("R12", "flag after stray end", int'(pkt_flag), 0);
        check("R12", "count after stray end", int'(cpu_count), 1);
        rd(0, "R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule